// File: doc/BRIEF.md
# Programmable Full-Duplex SPI Master

The block is an SPI master that exchanges one data unit at a time with an off-chip slave. While a unit shifts, it sends bits on the serial output and captures bits from the serial input in the same frame. Software programs it through a small register interface. The clock divider, the clock idle level, the drive edge, the sample edge, the unit width and the bit order can all be set. The slave-select output is either driven directly from a software bit or framed around each unit by hardware, and its active level is selectable.

A unit starts when software writes the transmit register while the controller is enabled and idle. Frame settings and transmit data are latched at that moment. When the unit ends, the received word lands in the receive register and a sticky done flag is set. That flag can raise an interrupt. Software clears the flag by writing 1 to it.

Top module: `spi_unit_master`

Register map (addr_i): 0 control, 1 divider, 2 select, 3 transmit (write), 4 receive (read), 5 status. Control bits: [0] enable, [1] clock idle level, [2] drive on falling edge, [3] sample on falling edge, [4] LSB first, [5] interrupt enable, [10:6] unit width. Select bits: [0] manual select, [1] active high, [2] automatic. Status bits: [0] done, [1] busy.

## Requirements
- R1: After reset, sclk_o is 0, ss_o is 1, irq_o is 0, status reads 0 and control reads 0x200 (width 8, everything else off).
- R2: One SPI half-period lasts divider+1 controller clocks. A unit takes one half-period of lead, then 2N clock edges spaced one half-period apart, then one half-period of trail, where N is the unit width.
- R3: While no unit is shifting, sclk_o rests at the level of control bit 1 (0 = low), and each unit starts and ends at that level.
- R4: Control bit 2 chooses the drive edge (1 = falling, 0 = rising). The slave, sampling on the programmed sample edge, receives the transmit word.
- R5: Control bit 3 chooses the sample edge (0 = rising, 1 = falling). The bits sampled from miso_i form the receive register, which holds its value until the next unit completes.
- R6: Control field [10:6] sets N in bits. The value 0 means 32 bits.
- R7: Control bit 4 set sends and assembles bits LSB first. Clear means MSB first.
- R8: With select bit 2 clear, ss_o is active exactly when select bit 0 is 1. The active level is high when select bit 1 is 1 and low when it is 0.
- R9: With select bit 2 set, ss_o is active from the start of the lead through the end of the trail, and inactive otherwise.
- R10: A transmit write while enable is 0, or while a unit is shifting, is ignored. No unit starts and the unit in flight is not altered.
- R11: Status bit 0 sets in the cycle a unit completes and stays set until software writes 1 to it. irq_o equals that flag ANDed with control bit 5.
- R12: Status bit 1 reads 1 from the cycle after the starting write until the unit completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_o | output | 1 | Slave select |
| irq_o | output | 1 | Unit-done interrupt |

## Verification
A wrong half-period count or edge counter shows as an sclk_o edge that lands early or late, or as a busy bit that drops in the wrong cycle. The bench compares its model with the ports on every clock, so such a fault is caught within one controller cycle. A wrong drive edge, sample edge or bit index does not show until the unit ends: the slave then holds the wrong word, or the receive register reads back wrong. Select framing and the done flag are compared every cycle, so a select that opens late or a flag that sets early is reported in the cycle it happens.

// File: rtl/spi_um_pkg.sv
package spi_um_pkg;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 9;
  localparam int LEN_W  = 5;
  localparam int ADDR_W = 3;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CNT_W  = $clog2(2 * DATA_W);
  localparam int WD_W   = 6 + LEN_W;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SSEL = 3'd2;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} phase_e;

  typedef struct packed {
    logic             cpol;
    logic             tx_fall;
    logic             rx_fall;
    logic             lsb_first;
    logic [LEN_W-1:0] width;
  } frame_cfg_t;
endpackage

// File: rtl/spi_um_half_timer.sv
module spi_um_half_timer
  import spi_um_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_um_shifter.sv
module spi_um_shifter
  import spi_um_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  frame_cfg_t        cfg_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  phase_e            st_q;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  edge_q, txc_q, rxc_q;
  logic              sclk_q;
  logic [CNT_W-1:0]  nbits, last_edge;
  logic              rising, rx_edge, tx_edge;

  assign nbits     = (cfg_q.width == '0) ? CNT_W'(DATA_W) : CNT_W'(cfg_q.width);
  assign last_edge = CNT_W'({nbits, 1'b0} - (CNT_W+1)'(1));
  // edge parity against idle level tells rising from falling
  assign rising    = (edge_q[0] == cfg_q.cpol);
  assign rx_edge   = rising ^ cfg_q.rx_fall;
  assign tx_edge   = rising ^ cfg_q.tx_fall;

  function automatic logic [IDX_W-1:0] bit_idx(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] r;
    r = cfg_q.lsb_first ? c : nbits + ~c;
    return r[IDX_W-1:0];
  endfunction

  assign mosi_o = (st_q != ST_IDLE) && tx_q[bit_idx(txc_q)];
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_TRAIL) && tick_i;
  assign sclk_o = sclk_q;
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      edge_q <= '0;
      txc_q  <= '0;
      rxc_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          sclk_q <= cfg_i.cpol;
          if (start_i) begin
            cfg_q  <= cfg_i;
            tx_q   <= tx_i;
            rx_q   <= '0;
            edge_q <= '0;
            txc_q  <= '0;
            rxc_q  <= '0;
            st_q   <= ST_LEAD;
          end
        end
        ST_LEAD: if (tick_i) st_q <= ST_SHIFT;
        ST_SHIFT: if (tick_i) begin
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
          if (rx_edge) begin
            rx_q[bit_idx(rxc_q)] <= miso_i;
            rxc_q <= rxc_q + 1'b1;
          end
          // first bit is pre-driven in lead; a lone drive edge first must not skip it
          if (tx_edge && !(edge_q == '0 && !rx_edge)) txc_q <= txc_q + 1'b1;
          if (edge_q == last_edge) st_q <= ST_TRAIL;
        end
        ST_TRAIL: if (tick_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_um_regs.sv
module spi_um_regs
  import spi_um_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WD_W-1:0]   wd_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic [DATA_W-1:0] rdata_o,
  output frame_cfg_t        cfg_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              en_o,
  output logic              ss_on_o,
  output logic              ss_pol_o,
  output logic              ss_auto_o,
  output logic              start_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic              en_q, irq_en_q, ss_on_q, ss_pol_q, ss_auto_q, flag_q;
  frame_cfg_t        cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] rx_q;
  logic              wr_ctrl, wr_div, wr_ssel, wr_stat;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_div  = wr_en_i && (addr_i == A_DIV);
  assign wr_ssel = wr_en_i && (addr_i == A_SSEL);
  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign start_o = wr_en_i && (addr_i == A_TX) && en_q && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      irq_en_q  <= 1'b0;
      cfg_q     <= '{cpol: 1'b0, tx_fall: 1'b0, rx_fall: 1'b0, lsb_first: 1'b0, width: LEN_W'(8)};
      div_q     <= '0;
      ss_on_q   <= 1'b0;
      ss_pol_q  <= 1'b0;
      ss_auto_q <= 1'b0;
      rx_q      <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q            <= wd_i[0];
        cfg_q.cpol      <= wd_i[1];
        cfg_q.tx_fall   <= wd_i[2];
        cfg_q.rx_fall   <= wd_i[3];
        cfg_q.lsb_first <= wd_i[4];
        irq_en_q        <= wd_i[5];
        cfg_q.width     <= wd_i[6 +: LEN_W];
      end
      if (wr_div) div_q <= wd_i[DIV_W-1:0];
      if (wr_ssel) begin
        ss_on_q   <= wd_i[0];
        ss_pol_q  <= wd_i[1];
        ss_auto_q <= wd_i[2];
      end
      if (done_i) rx_q <= rx_i;
      if (done_i)                  flag_q <= 1'b1;
      else if (wr_stat && wd_i[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[0]            = en_q;
        rdata_o[1]            = cfg_q.cpol;
        rdata_o[2]            = cfg_q.tx_fall;
        rdata_o[3]            = cfg_q.rx_fall;
        rdata_o[4]            = cfg_q.lsb_first;
        rdata_o[5]            = irq_en_q;
        rdata_o[6 +: LEN_W]   = cfg_q.width;
      end
      A_DIV:  rdata_o[DIV_W-1:0] = div_q;
      A_SSEL: rdata_o[2:0] = {ss_auto_q, ss_pol_q, ss_on_q};
      A_RX:   rdata_o = rx_q;
      A_STAT: rdata_o[1:0] = {busy_i, flag_q};
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign div_o     = div_q;
  assign en_o      = en_q;
  assign ss_on_o   = ss_on_q;
  assign ss_pol_o  = ss_pol_q;
  assign ss_auto_o = ss_auto_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q && irq_en_q;
endmodule

// File: rtl/spi_unit_master.sv
module spi_unit_master
  import spi_um_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_o,
  output logic              irq_o
);
  frame_cfg_t        cfg_w;
  logic [DIV_W-1:0]  div_w;
  logic              en_w, ss_on_w, ss_pol_w, ss_auto_w, start_w, flag_w;
  logic              busy_w, done_w, tick_w, ss_act_w;
  logic [DATA_W-1:0] rx_w;

  spi_um_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i,
    .wd_i      (wdata_i[WD_W-1:0]),
    .busy_i    (busy_w),
    .done_i    (done_w),
    .rx_i      (rx_w),
    .rdata_o,
    .cfg_o     (cfg_w),
    .div_o     (div_w),
    .en_o      (en_w),
    .ss_on_o   (ss_on_w),
    .ss_pol_o  (ss_pol_w),
    .ss_auto_o (ss_auto_w),
    .start_o   (start_w),
    .flag_o    (flag_w),
    .irq_o
  );

  spi_um_half_timer #(.DW(DIV_W)) u_timer (
    .clk_i, .rst_ni,
    .run_i  (busy_w),
    .div_i  (div_w),
    .tick_o (tick_w)
  );

  spi_um_shifter u_core (
    .clk_i, .rst_ni,
    .start_i (start_w),
    .cfg_i   (cfg_w),
    .tx_i    (wdata_i),
    .tick_i  (tick_w),
    .miso_i,
    .sclk_o,
    .mosi_o,
    .busy_o  (busy_w),
    .done_o  (done_w),
    .rx_o    (rx_w)
  );

  assign ss_act_w = ss_auto_w ? busy_w : ss_on_w;
  assign ss_o     = ss_pol_w ? ss_act_w : ~ss_act_w;
endmodule

// File: rtl/spi_um_chk.sv
module spi_um_chk
  import spi_um_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              busy_i,
  input logic              flag_i,
  input logic              sclk_i,
  input logic              ss_i,
  input logic              ss_auto_i,
  input logic              ss_pol_i,
  input logic              cpol_i,
  input logic              en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i
);
  // R2
  sclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tick_i) |=> $stable(sclk_i));

  // R3
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (sclk_i == $past(cpol_i)));

  // R9
  auto_ss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_auto_i && busy_i && (sclk_i != $past(sclk_i))) |-> (ss_i == ss_pol_i));

  // R10
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(wr_en_i && (addr_i == A_TX) && en_i));

  // R11
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $fell(busy_i));
endmodule

bind spi_unit_master spi_um_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_w),
  .busy_i    (busy_w),
  .flag_i    (flag_w),
  .sclk_i    (sclk_o),
  .ss_i      (ss_o),
  .ss_auto_i (ss_auto_w),
  .ss_pol_i  (ss_pol_w),
  .cpol_i    (cfg_w.cpol),
  .en_i      (en_w),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i)
);

// File: tb/tb_spi_unit_master.sv
`timescale 1ns/1ps
module tb_spi_unit_master;
  import spi_um_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  addr = A_STAT;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, ss, irq;
  logic        miso = 1'b0;

  spi_unit_master dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .ss_o(ss), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit live = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model state
  bit m_en, m_cpol, m_txf, m_rxf, m_lsb, m_irqen, m_sson, m_pol, m_auto, m_done, idle_lvl;
  int m_width = 8, m_div = 0;
  bit act = 0;
  int m = 0, H = 1, N = 8, end_m = 0;
  bit f_cpol, f_rxf, f_lsb;
  logic [31:0] slave_word, got_word, tx_word;
  int sc;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;

  function automatic int nb(input int w); return (w == 0) ? 32 : w; endfunction
  function automatic logic [31:0] mask(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction
  function automatic int bidx(input int j); return f_lsb ? j : N - 1 - j; endfunction
  function automatic bit m_busy(); return act && (m < end_m); endfunction

  always @(posedge clk) begin
    bit b, started;
    if (rst_n) begin
      b = m_busy();
      started = 0;
      idle_lvl = m_cpol;
      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            m_en = wdata[0]; m_cpol = wdata[1]; m_txf = wdata[2]; m_rxf = wdata[3];
            m_lsb = wdata[4]; m_irqen = wdata[5]; m_width = int'(wdata[10:6]);
          end
          A_DIV:  m_div = int'(wdata[8:0]);
          A_SSEL: begin m_sson = wdata[0]; m_pol = wdata[1]; m_auto = wdata[2]; end
          A_TX: if (m_en && !b) begin
            started = 1; act = 1; m = 0; H = m_div + 1; N = nb(m_width);
            end_m = H * (2 * N + 2);
            f_cpol = m_cpol; f_rxf = m_rxf; f_lsb = m_lsb;
            tx_word = wdata; got_word = '0; sc = 0;
            miso <= slave_word[bidx(0)];
          end
          A_STAT: if (wdata[0]) m_done = 0;
          default: ;
        endcase
      end
      if (act && !started) begin
        m++;
        if (m == end_m) m_done = 1;
      end
    end
  end

  always @(negedge clk) begin
    bit b, es, a, exs, rising;
    int e;
    if (rst_n && live) begin
      b = m_busy();
      e = m / H - 1;
      if (e < 0) e = 0;
      if (e > 2 * N) e = 2 * N;
      es = b ? (f_cpol ^ e[0]) : idle_lvl;
      chk(sclk === es, "R2/R3 sclk level", 64'(sclk), 64'(es));
      a = m_auto ? b : m_sson;
      exs = m_pol ? a : !a;
      chk(ss === exs, "R8/R9 select level", 64'(ss), 64'(exs));
      if (!wr_en && addr == A_STAT)
        chk(rdata[1:0] === {b, m_done}, "R11/R12 status", 64'(rdata[1:0]), 64'({b, m_done}));
      chk(irq === (m_done && m_irqen), "R11 irq", 64'(irq), 64'(m_done && m_irqen));
      if (b && sclk !== prev_sclk) begin
        rising = sclk;
        if (rising ^ f_rxf) begin
          got_word[bidx(sc)] = prev_mosi;
          sc++;
          if (sc < N) miso = slave_word[bidx(sc)];
        end
      end
    end
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); #1; wr_en = 1'b0; addr = A_STAT;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1; addr = a;
    @(negedge clk);
    chk(rdata === exp, tag, 64'(rdata), 64'(exp));
    #1; addr = A_STAT;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && m_busy(); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] tx, input logic [31:0] sl, input string tag);
    slave_word = sl;
    wr(A_TX, tx);
    wait_idle();
    chk(got_word === (tx & mask(N)), {tag, " R4 slave received"}, 64'(got_word), 64'(tx & mask(N)));
    rd(A_RX, sl & mask(N), {tag, " R5 receive register"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk === 1'b0, "R1 sclk in reset", 64'(sclk), 0);
    chk(ss === 1'b1, "R1 ss in reset", 64'(ss), 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0, "R1 irq after reset", 64'(irq), 0);
    rd(A_CTRL, 32'h200, "R1 control reset value");
    rd(A_STAT, 32'h0, "R1 status reset value");
    live = 1;

    // MSB first, idle low, drive falling, sample rising, byte
    wr(A_DIV, 1);
    wr(A_SSEL, 32'h1);
    wr(A_CTRL, 32'h205);
    xfer(32'hA5, 32'h3C, "T1");
    rd(A_STAT, 32'h1, "R11 done flag held");
    wr(A_STAT, 32'h1);
    rd(A_STAT, 32'h0, "R11 done flag cleared by write 1");

    // idle high, sample falling, LSB first, 12 bits, auto select
    wr(A_DIV, 3);
    wr(A_SSEL, 32'h4);
    wr(A_CTRL, 32'h31B);
    xfer(32'h9C3, 32'h5A6, "R7 lsb first");

    // 32-bit unit, drive edge first, active-high auto select, fastest clock
    wr(A_DIV, 0);
    wr(A_SSEL, 32'h6);
    wr(A_CTRL, 32'h009);
    xfer(32'hDEAD_BEEF, 32'h1234_5678, "R6 width 0 as 32");

    // same edge for drive and sample; second write during busy ignored
    wr(A_STAT, 32'h1);
    wr(A_DIV, 2);
    wr(A_SSEL, 32'h1);
    wr(A_CTRL, 32'h201);
    slave_word = 32'h81;
    wr(A_TX, 32'h66);
    repeat (4) @(negedge clk);
    chk(rdata[1] === 1'b1, "R12 busy while shifting", 64'(rdata[1]), 1);
    wr(A_TX, 32'hFF);
    wait_idle();
    chk(got_word === 32'h66, "R10 write while busy ignored", 64'(got_word), 64'h66);
    rd(A_RX, 32'h81, "R5 receive same-edge mode");

    // disabled controller ignores transmit writes
    wr(A_STAT, 32'h1);
    wr(A_CTRL, 32'h200);
    wr(A_TX, 32'h11);
    repeat (2) @(negedge clk);
    chk(rdata[1:0] === 2'b00, "R10 no start while disabled", 64'(rdata[1:0]), 0);

    // interrupt
    wr(A_CTRL, 32'h221);
    xfer(32'h3E, 32'hC1, "T5");
    chk(irq === 1'b1, "R11 irq raised", 64'(irq), 1);
    wr(A_STAT, 32'h1);
    @(negedge clk);
    chk(irq === 1'b0, "R11 irq cleared", 64'(irq), 0);

    // manual select, active high
    wr(A_SSEL, 32'h3);
    @(negedge clk);
    chk(ss === 1'b1, "R8 manual active high", 64'(ss), 1);
    wr(A_SSEL, 32'h2);
    @(negedge clk);
    chk(ss === 1'b0, "R8 manual inactive high-pol", 64'(ss), 0);

    live = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule